// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Chopper Controller

This block sequences one bridge of a current-regulated motor driver. While drive is requested it switches the bridge on and watches a digital over-threshold flag that comes from an external current comparator. The flag is masked for a short window after every turn-on, so that switching spikes cannot end the on phase early. Once the flag is honoured, the controller runs an off-time of fixed length. That off-time has two halves: the first uses fast decay and the second uses slow decay. When the off-time is over the bridge turns on again and the blanking window starts afresh.

A forced dead time, with every driver off, separates any two drive states. This covers leaving idle, going from on to fast decay, from fast to slow, from slow back to on, and shutting down. Synchronous rectification is enabled only inside the two decay phases. It is withdrawn for the rest of an off-time as soon as the zero-current input reports that the load current has reached zero, so that the current cannot reverse. All durations are parameters counted in clock cycles.

Top module: `chop_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `phase_o` is IDLE (0) and `chop_o` and `sr_o` are low.
- R2: `phase_o` uses the codes IDLE=0, ON=1, DEAD=2, FAST=3, SLOW=4. When `drive_req` rises from IDLE, the next DEAD_CYC cycles show DEAD, and ON follows them.
- R3: In the first BLANK_CYC cycles of each ON phase, `trip` is ignored. When `trip` is high in ON cycle j with j >= BLANK_CYC (cycles counted from 0), the phase leaves ON after that cycle.
- R4: Count the cycles after an honoured trip from k = 0. Cycles k < DEAD_CYC are DEAD, then FAST lasts until k = OFF_CYC/2 - 1, then DEAD_CYC more cycles are DEAD, then SLOW lasts until k = OFF_CYC - 1. `chop_o` is high for all OFF_CYC of these cycles.
- R5: After the off-time, DEAD_CYC cycles of DEAD follow with `chop_o` low, and then ON begins with its blanking window restarted.
- R6: Any change of `phase_o` between two values other than DEAD passes through at least one DEAD cycle.
- R7: `sr_o` is high only while `phase_o` is FAST or SLOW. It is low in every DEAD, ON and IDLE cycle.
- R8: If `zero_cur` is high in off-time cycle k, `sr_o` stays low from cycle k+1 to the end of that off-time. The next off-time enables rectification again.
- R9: When `drive_req` is low in a cycle that is not IDLE and is not already part of a shutdown, the next cycle starts a full DEAD_CYC cycles of DEAD, and IDLE follows. During this, `chop_o` and `sr_o` stay low, and a concurrent `trip` has no effect.
- R10: `trip` has no effect outside the ON phase, including during DEAD, FAST and SLOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| drive_req | input | 1 | Request to drive the bridge |
| trip | input | 1 | Current comparator over-threshold flag |
| zero_cur | input | 1 | Load current at zero |
| phase_o | output | 3 | Current drive phase (IDLE/ON/DEAD/FAST/SLOW) |
| chop_o | output | 1 | High while a fixed off-time is running |
| sr_o | output | 1 | Synchronous rectification enable |

## Verification
Two functions can land in the same cycle: the end of blanking, where a held trip is honoured, and the removal of drive request. Shutdown must win in that case and still give a full dead time. The bench starts a chop with trip held high and drops drive request at every cycle offset across the lead-in dead time, the blanked and open on phase, both decay halves, the crossover dead times and the return. Each time it expects exactly DEAD_CYC cycles of DEAD and then IDLE. A second sweep moves the trip onset across the blanking boundary and places zero-current pulses in each off-time region. The expected phase of every cycle is computed from the cycle index.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ON   = 3'd1,
    PH_DEAD = 3'd2,
    PH_FAST = 3'd3,
    PH_SLOW = 3'd4
  } chop_phase_t;
endpackage

// File: rtl/chop_cnt.sv
// Saturating up-counter with synchronous clear.
module chop_cnt #(
  parameter int MAXV = 1,
  parameter int W    = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      val <= '0;
    else if (en && (val != W'(MAXV)))
      val <= val + 1'b1;
  end
endmodule

// File: rtl/chop_sr_gate.sv
// Rectification enable: only in decay phases, withdrawn after zero current.
module chop_sr_gate (
  input  logic clk,
  input  logic rst,
  input  logic in_off,
  input  logic enter_on,
  input  logic zero_cur,
  input  logic nxt_decay,
  output logic sr_en
);
  logic zc_seen;
  logic zc_now;

  assign zc_now = in_off && zero_cur;

  always_ff @(posedge clk) begin
    if (rst || enter_on)
      zc_seen <= 1'b0;
    else if (zc_now)
      zc_seen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      sr_en <= 1'b0;
    else
      sr_en <= nxt_decay && !zc_seen && !zc_now;
  end
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 750,
  parameter int OFF_CYC   = 6250,
  parameter int DEAD_CYC  = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       drive_req,
  input  logic       trip,
  input  logic       zero_cur,
  output logic [2:0] phase_o,
  output logic       chop_o,
  output logic       sr_o
);
  localparam int HALF_CYC = OFF_CYC / 2;
  localparam int BW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);
  localparam int OW = $clog2(OFF_CYC + 1);
  localparam int DW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);

  chop_phase_t phase_q, tgt_q, nxt_ph, nxt_tgt;
  logic        chop_q, nxt_chop;
  logic [BW-1:0] blank_v;
  logic [OW-1:0] off_v;
  logic [DW-1:0] dead_v;
  logic blank_done, dead_done, fast_end, slow_end;
  logic trip_take, dead_clr, enter_on, nxt_decay;

  assign blank_done = (blank_v == BW'(BLANK_CYC));
  assign dead_done  = (dead_v  == DW'(DEAD_CYC - 1));
  assign fast_end   = (off_v   == OW'(HALF_CYC - 1));
  assign slow_end   = (off_v   == OW'(OFF_CYC - 1));
  assign trip_take  = drive_req && (phase_q == PH_ON) && blank_done && trip;

  always_comb begin
    nxt_ph  = phase_q;
    nxt_tgt = tgt_q;
    if (!drive_req) begin
      if (phase_q == PH_DEAD && tgt_q == PH_IDLE) begin
        if (dead_done) nxt_ph = PH_IDLE;
      end else if (phase_q != PH_IDLE) begin
        nxt_ph  = PH_DEAD;
        nxt_tgt = PH_IDLE;
      end
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          nxt_ph  = PH_DEAD;
          nxt_tgt = PH_ON;
        end
        PH_DEAD: if (dead_done) nxt_ph = tgt_q;
        PH_ON: if (trip_take) begin
          nxt_ph  = PH_DEAD;
          nxt_tgt = PH_FAST;
        end
        PH_FAST: if (fast_end) begin
          nxt_ph  = PH_DEAD;
          nxt_tgt = PH_SLOW;
        end
        PH_SLOW: if (slow_end) begin
          nxt_ph  = PH_DEAD;
          nxt_tgt = PH_ON;
        end
        default: nxt_ph = PH_IDLE;
      endcase
    end
  end

  assign nxt_decay = (nxt_ph == PH_FAST) || (nxt_ph == PH_SLOW);
  assign nxt_chop  = nxt_decay ||
                     ((nxt_ph == PH_DEAD) && ((nxt_tgt == PH_FAST) || (nxt_tgt == PH_SLOW)));
  assign dead_clr  = (nxt_ph == PH_DEAD) && ((phase_q != PH_DEAD) || (nxt_tgt != tgt_q));
  assign enter_on  = (nxt_ph == PH_ON) && (phase_q != PH_ON);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      tgt_q   <= PH_IDLE;
      chop_q  <= 1'b0;
    end else begin
      phase_q <= nxt_ph;
      tgt_q   <= nxt_tgt;
      chop_q  <= nxt_chop;
    end
  end

  chop_cnt #(.MAXV(BLANK_CYC), .W(BW)) u_blank (
    .clk(clk), .rst(rst), .clr(phase_q != PH_ON), .en(phase_q == PH_ON), .val(blank_v));

  chop_cnt #(.MAXV(OFF_CYC), .W(OW)) u_off (
    .clk(clk), .rst(rst), .clr(trip_take), .en(chop_q), .val(off_v));

  chop_cnt #(.MAXV(DEAD_CYC), .W(DW)) u_dead (
    .clk(clk), .rst(rst), .clr(dead_clr), .en(phase_q == PH_DEAD), .val(dead_v));

  chop_sr_gate u_sr (
    .clk(clk), .rst(rst), .in_off(chop_q), .enter_on(enter_on),
    .zero_cur(zero_cur), .nxt_decay(nxt_decay), .sr_en(sr_o));

  assign phase_o = phase_q;
  assign chop_o  = chop_q;
endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk
  import chop_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       drive_req,
  input logic [2:0] phase_o,
  input logic       chop_o,
  input logic       sr_o
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (phase_o == PH_IDLE) && !chop_o && !sr_o);

  // R6
  dead_between_chk: assert property (@(posedge clk) disable iff (rst)
    ((phase_o != $past(phase_o)) && (phase_o != PH_DEAD)) |-> ($past(phase_o) == PH_DEAD));

  // R7
  sr_decay_only_chk: assert property (@(posedge clk) disable iff (rst)
    sr_o |-> ((phase_o == PH_FAST) || (phase_o == PH_SLOW)));

  // R4
  chop_phase_chk: assert property (@(posedge clk) disable iff (rst)
    chop_o |-> ((phase_o == PH_DEAD) || (phase_o == PH_FAST) || (phase_o == PH_SLOW)));

  // R9
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !drive_req |=> ((phase_o == PH_DEAD) || (phase_o == PH_IDLE)) && !chop_o && !sr_o);

  // R3
  blank_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ((phase_o == PH_ON) && ($past(phase_o) != PH_ON) && drive_req) |=> (phase_o == PH_ON));
endmodule

bind chop_ctrl chop_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .drive_req(drive_req),
  .phase_o(phase_o), .chop_o(chop_o), .sr_o(sr_o));

// File: tb/sim_chop_ctrl.sv
module sim_chop_ctrl;
  localparam int B = 5, OFF = 20, D = 3, H = OFF / 2;
  localparam int IDLE = 0, ON = 1, DEAD = 2, FAST = 3, SLOW = 4;

  logic clk = 1'b0, rst = 1'b1, drive_req = 1'b0, trip = 1'b0, zero_cur = 1'b0;
  logic [2:0] phase;
  logic chop, sr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chop_ctrl #(.BLANK_CYC(B), .OFF_CYC(OFF), .DEAD_CYC(D)) u0 (
    .clk(clk), .rst(rst), .drive_req(drive_req), .trip(trip), .zero_cur(zero_cur),
    .phase_o(phase), .chop_o(chop), .sr_o(sr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic see(input int ph, input bit ch, input bit s, input string req);
    chk(phase == 3'(ph), {req, " phase"}, int'(phase), ph);
    chk(chop == ch, {req, " chop"}, int'(chop), int'(ch));
    chk(sr == s, {req, " sr"}, int'(sr), int'(s));
  endtask

  function automatic int off_phase(input int k);
    if (k < D) return DEAD;
    if (k < H) return FAST;
    if (k < H + D) return DEAD;
    return SLOW;
  endfunction

  // One full chop: trip raised in ON cycle t, zero-current pulse in off cycle zk (-1: none)
  task automatic run(input int t, input int zk, input bit trip_off);
    int m;
    m = (t > B) ? t : B;
    @(negedge clk); drive_req = 1'b1; trip = 1'b0; zero_cur = 1'b0;
    for (int i = 0; i < D; i++) begin @(negedge clk); see(DEAD, 0, 0, "R2"); end
    for (int j = 0; j <= m; j++) begin
      @(negedge clk); see(ON, 0, 0, (j < B) ? "R3" : "R2");
      if (j == t) trip = 1'b1;
    end
    for (int k = 0; k < OFF; k++) begin
      int ph;
      bit es;
      @(negedge clk);
      ph = off_phase(k);
      es = ((ph == FAST) || (ph == SLOW)) && !((zk >= 0) && (k > zk));
      see(ph, 1, es, (zk >= 0) ? "R8" : (trip_off ? "R10" : "R4"));
      trip = trip_off;
      zero_cur = (k == zk);
    end
    for (int i = 0; i < D; i++) begin
      @(negedge clk); see(DEAD, 0, 0, "R5");
      zero_cur = 1'b0;
    end
    @(negedge clk); see(ON, 0, 0, "R5");
    drive_req = 1'b0; trip = 1'b0;
    for (int i = 0; i < D; i++) begin @(negedge clk); see(DEAD, 0, 0, "R9"); end
    @(negedge clk); see(IDLE, 0, 0, "R9");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    see(IDLE, 0, 0, "R1");
    rst = 1'b0;
    @(negedge clk); see(IDLE, 0, 0, "R1");
    // trip onset swept across the blanking boundary; R3 R8 R10
    for (int t = 0; t <= 8; t++) begin
      int zk;
      zk = (t % 3 == 0) ? -1 : (t * 3) % OFF;
      if (t == 7) zk = 1;
      run(t, zk, t[0]);
    end
    // drive request dropped at every offset with trip held high; R9
    for (int s = 1; s <= D + B + 1 + OFF + D + 1; s++) begin
      @(negedge clk); drive_req = 1'b1; trip = 1'b1;
      repeat (s) @(negedge clk);
      drive_req = 1'b0;
      for (int i = 0; i < D; i++) begin @(negedge clk); see(DEAD, 0, 0, "R9"); end
      @(negedge clk); see(IDLE, 0, 0, "R9");
      trip = 1'b0;
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule